// File: doc/BRIEF.md
# Multi-Step Calibration Sequencer

This controller steps eight converter channels through a fixed calibration routine. A 3-bit command and a 4-bit data-select input are captured on each falling clock edge. A captured command is only acted on at the next rising edge of the frame pulse, which marks the start of each output-word period. The sequencer drives a step code to the modulators and a channel selector for the shared calibration current. It counts frames while a step runs and ignores every new command until the step has used up its fixed length.

At the end of a step the sequencer raises write strobes, and the results supplied on the result inputs are stored into a per-channel register file. That file can be read back through a small read port. The arithmetic that produces the results is outside this block. After reset, the sequencer waits for one frame edge before it treats itself as released. It then accepts the calibration steps in their fixed order: input offset voltage, quantizer-threshold (noise) calibration, system offset, and gain. The gain step walks the channels one by one.

Top module: `cal_step_sequencer`

## Requirements
- R1: While rst_n is low, busy, done, wr_mask and mdl_mode are all 0. Every noise, offset-high and offset-low register reads 0, and every gain register reads 0x199998.
- R2: Release from reset is taken at the first frame rising edge after rst_n goes high. A command already waiting at that edge is not started; it starts at the following frame edge.
- R3: cmd_in and data_sel are captured on the falling clock edge. mdl_mode, busy and chan_sel change only on a clock edge at which frame is high after having been low on the previous edge.
- R4: A command captured while data_sel is not 0 is ignored.
- R5: Command 1 (input offset voltage) is accepted from idle at any stage, and it restarts the order. Command 2 (noise) is accepted only right after command 1 has completed. Command 3 (system offset) is accepted only right after command 2. Command 4 (gain) is accepted only right after command 3. Any other calibration command arriving out of order is ignored.
- R6: Command codes 5, 6 and 7 are ignored, and the block stays in normal mode.
- R7: Once a step has started, changes on cmd_in and data_sel have no effect until it ends. Steps 1 and 2 last STEP_LEN frame edges after the starting edge. Step 3 lasts OFS_LEN edges.
- R8: The gain step calibrates channels 0 to 7 in turn, each for STEP_LEN frame edges. chan_sel names the active channel.
- R9: busy is high for the whole of a step. done is high for exactly one frame, from the edge that ends the step to the next frame edge.
- R10: At the ending edge, wr_mask pulses for one clock. The mask bits are: bit0 noise, bit1 offset-high, bit2 offset-low, bit3 gain. The noise step loads res_lo into every channel's noise register. The offset step loads res_hi and res_lo into every channel's offset-high and offset-low registers. Each gain channel loads res_lo into that channel's gain register. The input offset step writes nothing.
- R11: mdl_mode is 0 for normal, 1 for input offset, 2 for noise, 3 for system offset and 4 for gain. Codes 5 to 7 never appear. rd_sel chooses 0 noise, 1 offset-high, 2 offset-low, 3 gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame | input | 1 | Frame pulse, one per output word |
| cmd_in | input | 3 | Mode command |
| data_sel | input | 4 | Data select; must be 0 for a command to count |
| res_hi | input | W | Upper result word stored at step end |
| res_lo | input | W | Lower result word stored at step end |
| rd_chan | input | CHW | Read-back channel |
| rd_sel | input | 2 | Read-back register select |
| rd_data | output | W | Read-back data |
| mdl_mode | output | 3 | Step code to the modulators |
| chan_sel | output | CHW | Active channel for the shared calibration current |
| busy | output | 1 | A step is running |
| done | output | 1 | One-frame end-of-step flag |
| wr_mask | output | 4 | One-clock write strobes per register kind |

## Verification
The assertions assume three things about the inputs. Reset is held across at least one clock edge. frame is a pulse that is low on at least one sampling edge between any two highs. cmd_in and data_sel settle before the falling edge. The stimulus keeps to this by changing every input just after a rising edge, holding frame high for one clock and low for the next. It mixes random commands, random select values and random results with directed out-of-order and illegal commands. A bench model of the step order decides which commands are accepted.

// File: rtl/cal_step_sequencer.sv
module cal_step_sequencer #(
  parameter int W        = 24,
  parameter int NCH      = 8,
  parameter int STEP_LEN = 1028,
  parameter int OFS_LEN  = 1028,
  parameter logic [W-1:0] GAIN_RST = 24'h199998,
  localparam int CHW = $clog2(NCH),
  localparam int MAXL = (STEP_LEN > OFS_LEN) ? STEP_LEN : OFS_LEN,
  localparam int CW = $clog2(MAXL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame,
  input  logic [2:0]     cmd_in,
  input  logic [3:0]     data_sel,
  input  logic [W-1:0]   res_hi,
  input  logic [W-1:0]   res_lo,
  input  logic [CHW-1:0] rd_chan,
  input  logic [1:0]     rd_sel,
  output logic [W-1:0]   rd_data,
  output logic [2:0]     mdl_mode,
  output logic [CHW-1:0] chan_sel,
  output logic           busy,
  output logic           done,
  output logic [3:0]     wr_mask
);

  logic [2:0]     cmd_q;
  logic [3:0]     ds_q;
  logic           frame_d;
  logic           released;
  logic [2:0]     stage;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   rf [4][NCH];

  wire fr = frame & ~frame_d;
  wire [CW-1:0] last = (mdl_mode == 3'd3) ? CW'(OFS_LEN - 1) : CW'(STEP_LEN - 1);
  wire accept = (ds_q == 4'd0) &&
                ((cmd_q == 3'd1) ||
                 (cmd_q == 3'd2 && stage == 3'd1) ||
                 (cmd_q == 3'd3 && stage == 3'd2) ||
                 (cmd_q == 3'd4 && stage == 3'd3));

  assign rd_data = rf[rd_sel][rd_chan];

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q <= '0;
      ds_q  <= '0;
    end else begin
      cmd_q <= cmd_in;
      ds_q  <= data_sel;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_d <= 1'b0;
    else        frame_d <= frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mdl_mode <= '0;
      stage    <= '0;
      cnt      <= '0;
      chan_sel <= '0;
      wr_mask  <= '0;
      for (int i = 0; i < NCH; i++) begin
        rf[0][i] <= '0;
        rf[1][i] <= '0;
        rf[2][i] <= '0;
        rf[3][i] <= GAIN_RST;
      end
    end else begin
      wr_mask <= '0;
      if (fr) begin
        done <= 1'b0;
        if (!released) begin
          released <= 1'b1;
        end else if (busy) begin
          if (cnt == last) begin
            cnt <= '0;
            case (mdl_mode)
              3'd1: stage <= 3'd1;
              3'd2: begin
                stage   <= 3'd2;
                wr_mask <= 4'b0001;
                for (int i = 0; i < NCH; i++) rf[0][i] <= res_lo;
              end
              3'd3: begin
                stage   <= 3'd3;
                wr_mask <= 4'b0110;
                for (int i = 0; i < NCH; i++) begin
                  rf[1][i] <= res_hi;
                  rf[2][i] <= res_lo;
                end
              end
              default: begin
                wr_mask <= 4'b1000;
                rf[3][chan_sel] <= res_lo;
              end
            endcase
            if (mdl_mode != 3'd4 || chan_sel == CHW'(NCH - 1)) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              mdl_mode <= '0;
              chan_sel <= '0;
              if (mdl_mode == 3'd4) stage <= 3'd4;
            end else begin
              chan_sel <= chan_sel + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (accept) begin
          busy     <= 1'b1;
          mdl_mode <= cmd_q;
          cnt      <= '0;
          chan_sel <= '0;
        end
      end
    end
  end

endmodule

module cal_step_sequencer_chk #(
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame,
  input logic           frame_d,
  input logic           busy,
  input logic           done,
  input logic [2:0]     mdl_mode,
  input logic [CHW-1:0] chan_sel,
  input logic [3:0]     wr_mask
);

  // R9
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (mdl_mode != 3'd0));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  mode_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdl_mode != $past(mdl_mode)) |-> $past(frame && !frame_d));

  // R8
  chan_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != $past(chan_sel)) |-> $past(mdl_mode) == 3'd4);

  // R10
  wr_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask[3] |-> ($past(mdl_mode) == 3'd4 && wr_mask[2:0] == 3'd0));

  // R10
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != 4'd0) |-> $past(busy));

  // R11
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdl_mode <= 3'd4);

endmodule

bind cal_step_sequencer cal_step_sequencer_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame(frame), .frame_d(frame_d),
  .busy(busy), .done(done), .mdl_mode(mdl_mode),
  .chan_sel(chan_sel), .wr_mask(wr_mask)
);

// File: tb/cal_step_sequencer_test.sv
module cal_step_sequencer_test;
  localparam int CLK_P = 10;
  localparam int W  = 24;
  localparam int SL = 5;
  localparam int OL = 7;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, frame;
  logic [2:0] cmd_in;
  logic [3:0] data_sel;
  logic [W-1:0] res_hi, res_lo, rd_data;
  logic [2:0] rd_chan, chan_sel, mdl_mode;
  logic [1:0] rd_sel;
  logic busy, done;
  logic [3:0] wr_mask;

  cal_step_sequencer #(.W(W), .NCH(8), .STEP_LEN(SL), .OFS_LEN(OL)) uut (
    .clk(clk), .rst_n(rst_n), .frame(frame), .cmd_in(cmd_in), .data_sel(data_sel),
    .res_hi(res_hi), .res_lo(res_lo), .rd_chan(rd_chan), .rd_sel(rd_sel),
    .rd_data(rd_data), .mdl_mode(mdl_mode), .chan_sel(chan_sel),
    .busy(busy), .done(done), .wr_mask(wr_mask));

  int checks = 0, errors = 0, mst = 0;
  logic [W-1:0] exp_rf [4][8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1 frame = 1'b1;
    @(posedge clk); #1 frame = 1'b0;
  endtask

  function automatic bit exp_acc(int st, logic [2:0] c, logic [3:0] d);
    return d == 4'd0 && (c == 3'd1 || (c == 3'd2 && st == 1) ||
                         (c == 3'd3 && st == 2) || (c == 3'd4 && st == 3));
  endfunction

  function automatic logic [3:0] exp_mask(logic [2:0] c);
    case (c)
      3'd2: return 4'b0001;
      3'd3: return 4'b0110;
      3'd4: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check_rf(string req);
    for (int ch = 0; ch < 8; ch++)
      for (int s = 0; s < 4; s++) begin
        rd_chan = 3'(ch); rd_sel = 2'(s); #1;
        chk(req, 32'(rd_data), 32'(exp_rf[s][ch]));
      end
  endtask

  task automatic run_step(logic [2:0] c);
    int nch, len;
    nch = (c == 3'd4) ? 8 : 1;
    len = (c == 3'd3) ? OL : SL;
    cmd_in = c; data_sel = 4'd0;
    tick;
    chk("R9 busy at start", 32'(busy), 1);
    chk("R11 mode code", 32'(mdl_mode), 32'(c));
    for (int ch = 0; ch < nch; ch++)
      for (int k = 1; k <= len; k++) begin
        if (k == len) begin
          res_hi = W'($urandom);
          res_lo = W'($urandom);
        end
        cmd_in = 3'($urandom); data_sel = 4'($urandom);
        tick;
        if (k < len) begin
          chk("R7 busy held", 32'(busy), 1);
          chk("R7 mode held", 32'(mdl_mode), 32'(c));
          chk("R10 no early write", 32'(wr_mask), 0);
          if (c == 3'd4) chk("R8 channel", 32'(chan_sel), 32'(ch));
        end else begin
          chk("R10 write mask", 32'(wr_mask), 32'(exp_mask(c)));
          case (c)
            3'd2: for (int i = 0; i < 8; i++) exp_rf[0][i] = res_lo;
            3'd3: for (int i = 0; i < 8; i++) begin
                    exp_rf[1][i] = res_hi; exp_rf[2][i] = res_lo;
                  end
            3'd4: exp_rf[3][ch] = res_lo;
            default: ;
          endcase
          if (ch == nch - 1) begin
            chk("R9 busy end", 32'(busy), 0);
            chk("R9 done", 32'(done), 1);
          end else begin
            chk("R8 busy between channels", 32'(busy), 1);
            chk("R8 next channel", 32'(chan_sel), 32'(ch + 1));
          end
        end
      end
    mst = int'(c);
    cmd_in = 3'd0; data_sel = 4'd0;
    tick;
    chk("R9 done one frame", 32'(done), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] c;
    logic [3:0] d;
    void'($urandom(32'd4711));
    rst_n = 1'b0; frame = 1'b0; cmd_in = 3'd0; data_sel = 4'd0;
    res_hi = '0; res_lo = '0; rd_chan = '0; rd_sel = '0;
    for (int ch = 0; ch < 8; ch++) begin
      exp_rf[0][ch] = '0; exp_rf[1][ch] = '0; exp_rf[2][ch] = '0;
      exp_rf[3][ch] = 24'h199998;
    end
    repeat (4) @(posedge clk);
    #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mode", 32'(mdl_mode), 0);
    chk("R1 wr_mask", 32'(wr_mask), 0);
    check_rf("R1 register defaults");
    rst_n = 1'b1;

    cmd_in = 3'd1;
    tick;
    chk("R2 release edge ignores command", 32'(busy), 0);
    repeat (5) @(posedge clk);
    #1;
    chk("R3 no frame no start", 32'(busy), 0);
    run_step(3'd1);

    cmd_in = 3'd4; tick;
    chk("R5 out of order gain", 32'(busy), 0);
    cmd_in = 3'd6; tick;
    chk("R6 illegal code", 32'(busy), 0);
    chk("R6 stays normal", 32'(mdl_mode), 0);
    cmd_in = 3'd2; data_sel = 4'd3; tick;
    chk("R4 data select nonzero", 32'(busy), 0);
    data_sel = 4'd0;

    run_step(3'd2);
    check_rf("R10 noise registers");
    run_step(3'd3);
    check_rf("R10 offset registers");
    run_step(3'd4);
    check_rf("R10 gain registers");

    cmd_in = 3'd2; tick;
    chk("R5 noise after gain", 32'(busy), 0);

    for (int it = 0; it < 30; it++) begin
      c = 3'($urandom % 8);
      d = ($urandom % 3 == 0) ? 4'($urandom % 15 + 1) : 4'd0;
      if (exp_acc(mst, c, d)) run_step(c);
      else begin
        cmd_in = c; data_sel = d;
        tick;
        chk("R4 R5 R6 rejected", 32'(busy), 0);
        chk("R11 mode normal", 32'(mdl_mode), 0);
      end
    end
    cmd_in = 3'd0; data_sel = 4'd0;
    check_rf("R10 final registers");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule